// File: doc/BRIEF.md
# Peer Doorbell and Interrupt Register Block

This block holds the small register set of a shared-memory device that connects several processing peers. Software reaches it through single-word (32-bit) reads and writes inside a 256-byte window. The block keeps an interrupt enable mask and an interrupt status word, and it drives a level interrupt whenever an enabled status bit is set. It can also report the local node's own position number. A fourth register is write-only: writing it rings a doorbell on a remote peer.

A doorbell write names a destination peer and a vector number. The write is passed on only when the peer number lies within the configured population and the vector lies within that peer's configured vector count. An accepted write appears as a one-cycle notify pulse that carries both fields. Any other doorbell write disappears without a trace. Local events arrive as a byte on a separate strobe and replace the status word. Reading the status register hands back its value and clears it.

Per-peer vector counts, the highest valid peer number, the own position and a "shared memory present" flag are static configuration inputs. Read data comes back one cycle after the request, with its own valid strobe.

Top module: `pdb_regblock`

## Requirements
- R1: Registers are decoded on the byte address with bits 1:0 ignored. Mask is at 0x00, status at 0x04, own position at 0x08 and doorbell at 0x0C, so an access at 0x02 reaches the mask.
- R2: `irq` is high exactly when the bitwise AND of status and mask is nonzero. It follows a mask write in the cycle after that write.
- R3: A status read returns the status value held before the read. It then leaves the status at zero, so `irq` is low in the following cycle unless an event arrives.
- R4: A bus write to the status register replaces the whole word. An event strobe replaces the whole word with its zero-extended byte. Neither ORs into the old value.
- R5: When an event strobe and a status read fall in the same cycle, the read returns the old value and the status takes the event byte. The event is not lost.
- R6: An accepted doorbell write produces `ntf_valid` high for exactly one cycle, in the cycle after the write. `ntf_dest` is write-data bits 31:16 and `ntf_vec` is bits 7:0. Bits 15:8 have no effect.
- R7: A doorbell whose destination is greater than `cfg_max_peer`, or not below NUM_PEERS, produces no pulse.
- R8: A doorbell whose vector is not below the destination peer's configured count (field `[i*9 +: 9]` of `cfg_peer_vecs` for peer i) produces no pulse. A count of zero therefore blocks every vector.
- R9: A read of own position returns `cfg_own_id` zero-extended when `cfg_mapped` is 1, and 0xFFFFFFFF when it is 0.
- R10: Reads of the doorbell offset and of unused offsets return zero. Writes to the own-position offset or to unused offsets change neither mask nor status.
- R11: Reset clears status, `irq`, `ntf_valid` and `rd_valid`. The mask register keeps the value it held before reset.
- R12: `rd_valid` rises in the cycle after a read request and `rd_data` holds the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address in the register window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data |
| evt_valid | input | 1 | Local event strobe |
| evt_data | input | 8 | Local event byte, loaded into status |
| cfg_max_peer | input | 16 | Highest valid peer number |
| cfg_peer_vecs | input | 36 | Vector count per peer, 9 bits each, peer 0 lowest |
| cfg_own_id | input | 16 | Own position number |
| cfg_mapped | input | 1 | Shared memory present |
| irq | output | 1 | Level interrupt |
| ntf_valid | output | 1 | Doorbell notify pulse |
| ntf_dest | output | 16 | Notified peer |
| ntf_vec | output | 8 | Notified vector |

## Verification
The bench keeps the default build of four peer slots and 8-bit vectors. It sets the highest peer to 2 and the vector counts to 3, 1, 0 and 5. With these values one doorbell run can reach several cases: a peer with a zero count, a peer whose count would allow a vector but whose number lies above the peer limit, and a destination past the table size. The 8-bit event path and the full 32-bit status word together show the difference between replacing the status and ORing into it.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

  localparam int unsigned OFS_MASK = 'h00;
  localparam int unsigned OFS_STAT = 'h04;
  localparam int unsigned OFS_POSN = 'h08;
  localparam int unsigned OFS_BELL = 'h0C;

  typedef enum logic [1:0] {
    RSEL_ZERO = 2'd0,
    RSEL_MASK = 2'd1,
    RSEL_STAT = 2'd2,
    RSEL_POSN = 2'd3
  } rsel_e;

endpackage

// File: rtl/pdb_decode.sv
module pdb_decode
  import pdb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mask_we,
  output logic              stat_we,
  output logic              stat_rd,
  output logic              bell_we,
  output logic              rd_en,
  output rsel_e             rd_sel
);

  logic [ADDR_W-1:0] word_addr;
  logic              rd_req;
  logic              wr_req;

  assign word_addr = req_addr & ~ADDR_W'(3);
  assign rd_req    = req_valid & ~req_write;
  assign wr_req    = req_valid &  req_write;

  always_comb begin
    mask_we = 1'b0;
    stat_we = 1'b0;
    stat_rd = 1'b0;
    bell_we = 1'b0;
    rd_sel  = RSEL_ZERO;
    unique case (word_addr)
      ADDR_W'(OFS_MASK): begin
        mask_we = wr_req;
        rd_sel  = RSEL_MASK;
      end
      ADDR_W'(OFS_STAT): begin
        stat_we = wr_req;
        stat_rd = rd_req;
        rd_sel  = RSEL_STAT;
      end
      ADDR_W'(OFS_POSN): rd_sel  = RSEL_POSN;
      ADDR_W'(OFS_BELL): bell_we = wr_req;
      default: ;
    endcase
  end

  assign rd_en = rd_req;

endmodule

// File: rtl/pdb_irq.sv
module pdb_irq #(
  parameter int DATA_W = 32,
  parameter int EVT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              mask_we,
  input  logic              stat_we,
  input  logic              stat_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evt_valid,
  input  logic [EVT_W-1:0]  evt_data,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] stat_o,
  output logic              irq_o
);

  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] stat_d;
  logic              stat_en;

  // Priority low to high: read clear, bus write, local event.
  always_comb begin
    stat_d = stat_q;
    if (stat_rd)   stat_d = '0;
    if (stat_we)   stat_d = wdata;
    if (evt_valid) stat_d = DATA_W'(evt_data);
  end

  assign stat_en = stat_rd | stat_we | evt_valid;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  // Mask is outside the reset domain on purpose: it survives reset.
  always_ff @(posedge clk) begin
    if (mask_we) mask_q <= wdata;
  end

  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & mask_q);

  p_evt_load_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    evt_valid |=> stat_o == DATA_W'($past(evt_data)));

  p_rd_clear_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (stat_rd && !evt_valid && !stat_we) |=> stat_o == '0);

  p_irq_drop_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (stat_rd && !evt_valid && !stat_we) |=> !irq_o);

  p_stat_hold_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!stat_rd && !stat_we && !evt_valid) |=> $stable(stat_o));

endmodule

// File: rtl/pdb_ring.sv
module pdb_ring #(
  parameter int NUM_PEERS = 4,
  parameter int DEST_W    = 16,
  parameter int VEC_W     = 8,
  localparam int VCNT_W   = VEC_W + 1,
  localparam int IDX_W    = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        bell_we,
  input  logic [DEST_W-1:0]           wr_dest,
  input  logic [VEC_W-1:0]            wr_vec,
  input  logic [DEST_W-1:0]           cfg_max_peer,
  input  logic [NUM_PEERS*VCNT_W-1:0] cfg_peer_vecs,
  output logic                        ntf_valid,
  output logic [DEST_W-1:0]           ntf_dest,
  output logic [VEC_W-1:0]            ntf_vec
);

  logic [VCNT_W-1:0] vcnt [NUM_PEERS];

  for (genvar g = 0; g < NUM_PEERS; g++) begin : g_unpack
    assign vcnt[g] = cfg_peer_vecs[g*VCNT_W +: VCNT_W];
  end

  logic              dest_known;
  logic              dest_in_tbl;
  logic [IDX_W-1:0]  idx;
  logic [VCNT_W-1:0] sel_cnt;
  logic              vec_ok;
  logic              accept;

  assign dest_known  = (wr_dest <= cfg_max_peer);
  assign dest_in_tbl = (32'(wr_dest) < 32'(NUM_PEERS));
  assign idx         = wr_dest[IDX_W-1:0];

  always_comb begin
    sel_cnt = '0;
    if (dest_in_tbl) sel_cnt = vcnt[idx];
  end

  assign vec_ok = ({1'b0, wr_vec} < sel_cnt);
  assign accept = bell_we & dest_known & dest_in_tbl & vec_ok;

  logic              vld_q;
  logic [DEST_W-1:0] dest_q;
  logic [VEC_W-1:0]  vec_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      dest_q <= wr_dest;
      vec_q  <= wr_vec;
    end
  end

  assign ntf_valid = vld_q;
  assign ntf_dest  = dest_q;
  assign ntf_vec   = vec_q;

  p_ntf_cause_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    ntf_valid |-> $past(bell_we));

  p_ntf_range_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    ntf_valid |-> (ntf_dest <= $past(cfg_max_peer)));

  p_ntf_vec_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    ntf_valid |-> ({1'b0, ntf_vec} < $past(sel_cnt)));

endmodule

// File: rtl/pdb_regblock.sv
module pdb_regblock
  import pdb_pkg::*;
#(
  parameter int NUM_PEERS = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int DEST_W    = 16,
  parameter int VEC_W     = 8,
  parameter int EVT_W     = 8,
  parameter int ID_W      = 16,
  localparam int VCNT_W   = VEC_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        rd_valid,
  output logic [DATA_W-1:0]           rd_data,
  input  logic                        evt_valid,
  input  logic [EVT_W-1:0]            evt_data,
  input  logic [DEST_W-1:0]           cfg_max_peer,
  input  logic [NUM_PEERS*VCNT_W-1:0] cfg_peer_vecs,
  input  logic [ID_W-1:0]             cfg_own_id,
  input  logic                        cfg_mapped,
  output logic                        irq,
  output logic                        ntf_valid,
  output logic [DEST_W-1:0]           ntf_dest,
  output logic [VEC_W-1:0]            ntf_vec
);

  // Reset: asserts at once, releases after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic  mask_we, stat_we, stat_rd, bell_we, rd_en;
  rsel_e rd_sel;

  pdb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .mask_we   (mask_we),
    .stat_we   (stat_we),
    .stat_rd   (stat_rd),
    .bell_we   (bell_we),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel)
  );

  logic [DATA_W-1:0] mask_v, stat_v;

  pdb_irq #(.DATA_W(DATA_W), .EVT_W(EVT_W)) u_irq (
    .clk       (clk),
    .rst_ni    (rst_q_n),
    .mask_we   (mask_we),
    .stat_we   (stat_we),
    .stat_rd   (stat_rd),
    .wdata     (req_wdata),
    .evt_valid (evt_valid),
    .evt_data  (evt_data),
    .mask_o    (mask_v),
    .stat_o    (stat_v),
    .irq_o     (irq)
  );

  pdb_ring #(.NUM_PEERS(NUM_PEERS), .DEST_W(DEST_W), .VEC_W(VEC_W)) u_ring (
    .clk           (clk),
    .rst_ni        (rst_q_n),
    .bell_we       (bell_we),
    .wr_dest       (req_wdata[DATA_W-1 -: DEST_W]),
    .wr_vec        (req_wdata[VEC_W-1:0]),
    .cfg_max_peer  (cfg_max_peer),
    .cfg_peer_vecs (cfg_peer_vecs),
    .ntf_valid     (ntf_valid),
    .ntf_dest      (ntf_dest),
    .ntf_vec       (ntf_vec)
  );

  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rvld_q;

  always_comb begin
    unique case (rd_sel)
      RSEL_MASK: rdata_d = mask_v;
      RSEL_STAT: rdata_d = stat_v;
      RSEL_POSN: rdata_d = cfg_mapped ? DATA_W'(cfg_own_id) : '1;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) rvld_q <= 1'b0;
    else          rvld_q <= rd_en;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata_q <= rdata_d;
  end

  assign rd_valid = rvld_q;
  assign rd_data  = rdata_q;

  p_rd_latency_r12: assert property (@(posedge clk) disable iff (!rst_q_n)
    rd_valid |-> $past(req_valid && !req_write));

  p_bell_silent_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && !req_write) |=> rd_valid);

endmodule

// File: tb/pdb_regblock_tb_top.sv
`timescale 1ns/1ps
module pdb_regblock_tb_top;

  localparam int NP = 4;
  localparam int VW = 8;
  localparam int CW = VW + 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        evt_valid;
  logic [7:0]  evt_data;
  logic [15:0] cfg_max_peer;
  logic [NP*CW-1:0] cfg_peer_vecs;
  logic [15:0] cfg_own_id;
  logic        cfg_mapped;
  logic        irq, ntf_valid;
  logic [15:0] ntf_dest;
  logic [7:0]  ntf_vec;

  always #2 clk = ~clk;

  pdb_regblock dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .evt_valid(evt_valid), .evt_data(evt_data),
    .cfg_max_peer(cfg_max_peer), .cfg_peer_vecs(cfg_peer_vecs),
    .cfg_own_id(cfg_own_id), .cfg_mapped(cfg_mapped),
    .irq(irq), .ntf_valid(ntf_valid), .ntf_dest(ntf_dest), .ntf_vec(ntf_vec)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 rd_valid", {31'd0, rd_valid}, 32'd1);
    d = rd_data;
  endtask

  task automatic evt(input logic [7:0] b);
    @(negedge clk);
    evt_valid = 1'b1; evt_data = b;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R11 irq after reset", {31'd0, irq}, 32'd0);
    chk("R11 ntf_valid after reset", {31'd0, ntf_valid}, 32'd0);
    chk("R11 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
    bus_rd(8'h04, v);
    chk("R11 status after reset", v, 32'h0);
  endtask

  task automatic t_mask_irq();
    logic [31:0] v;
    bus_wr(8'h00, 32'h0);
    evt(8'h04);
    chk("R2 irq masked", {31'd0, irq}, 32'd0);
    bus_wr(8'h00, 32'h0000_0004);
    chk("R2 irq enabled", {31'd0, irq}, 32'd1);
    bus_wr(8'h00, 32'h0000_0003);
    chk("R2 irq disjoint mask", {31'd0, irq}, 32'd0);
    bus_wr(8'h02, 32'h0000_0004);
    bus_rd(8'h00, v);
    chk("R1 alias low bits to mask", v, 32'h0000_0004);
    chk("R1 irq via alias write", {31'd0, irq}, 32'd1);
    bus_rd(8'h05, v);
    chk("R1 alias read status", v, 32'h0000_0004);
  endtask

  task automatic t_status();
    logic [31:0] v;
    evt(8'h01);
    bus_wr(8'h04, 32'h0000_0100);
    bus_rd(8'h04, v);
    chk("R4 bus write replaces", v, 32'h0000_0100);
    bus_wr(8'h04, 32'h8000_0100);
    bus_wr(8'h00, 32'h0000_0100);
    chk("R2 irq bit8", {31'd0, irq}, 32'd1);
    bus_rd(8'h04, v);
    chk("R3 read returns value", v, 32'h8000_0100);
    chk("R3 irq drops after read", {31'd0, irq}, 32'd0);
    bus_rd(8'h04, v);
    chk("R3 status cleared", v, 32'h0);
    bus_wr(8'h04, 32'h0000_0F0F);
    evt(8'h30);
    bus_rd(8'h04, v);
    chk("R4 event replaces", v, 32'h0000_0030);
  endtask

  task automatic t_race();
    logic [31:0] v;
    bus_wr(8'h00, 32'h0000_00FF);
    evt(8'h11);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h04;
    evt_valid = 1'b1; evt_data = 8'h5A;
    @(negedge clk);
    req_valid = 1'b0; evt_valid = 1'b0;
    chk("R5 read returns old", rd_data, 32'h0000_0011);
    chk("R5 irq held by event", {31'd0, irq}, 32'd1);
    bus_rd(8'h04, v);
    chk("R5 event kept", v, 32'h0000_005A);
  endtask

  task automatic bell(input logic [15:0] d, input logic [7:0] junk,
                      input logic [7:0] vec, input bit ok, input string req);
    bus_wr(8'h0C, {d, junk, vec});
    chk({req, " pulse"}, {31'd0, ntf_valid}, {31'd0, ok});
    if (ok) begin
      chk({req, " dest"}, {16'd0, ntf_dest}, {16'd0, d});
      chk({req, " vec"}, {24'd0, ntf_vec}, {24'd0, vec});
    end
    @(negedge clk);
    chk({req, " pulse ends"}, {31'd0, ntf_valid}, 32'd0);
  endtask

  task automatic t_bell();
    bell(16'd0, 8'hAB, 8'd2, 1'b1, "R6 peer0 vec2");
    bell(16'd1, 8'h00, 8'd0, 1'b1, "R6 peer1 vec0");
    bell(16'd2, 8'h00, 8'd0, 1'b0, "R8 zero count");
    bell(16'd0, 8'h00, 8'd3, 1'b0, "R8 vec at count");
    bell(16'd0, 8'h00, 8'hFF, 1'b0, "R8 vec 0xFF");
    bell(16'd3, 8'h00, 8'd0, 1'b0, "R7 above max peer");
    bell(16'h0100, 8'h00, 8'd0, 1'b0, "R7 far dest");
    cfg_max_peer = 16'hFFFF;
    bell(16'd4, 8'h00, 8'd0, 1'b0, "R7 beyond table");
    bell(16'd3, 8'h00, 8'd4, 1'b1, "R6 peer3 vec4");
    cfg_max_peer = 16'd2;
  endtask

  task automatic t_posn_undef();
    logic [31:0] v;
    bus_rd(8'h08, v);
    chk("R9 own id mapped", v, 32'h0000_0007);
    cfg_mapped = 1'b0;
    bus_rd(8'h08, v);
    chk("R9 own id unmapped", v, 32'hFFFF_FFFF);
    cfg_mapped = 1'b1;
    bus_rd(8'h0C, v);
    chk("R10 doorbell reads zero", v, 32'h0);
    bus_rd(8'h40, v);
    chk("R10 undefined reads zero", v, 32'h0);
    bus_wr(8'h00, 32'h0000_00C3);
    evt(8'h21);
    bus_wr(8'h08, 32'hDEAD_BEEF);
    bus_wr(8'h40, 32'h1234_5678);
    bus_wr(8'hFC, 32'hFFFF_FFFF);
    bus_rd(8'h00, v);
    chk("R10 mask untouched", v, 32'h0000_00C3);
    bus_rd(8'h04, v);
    chk("R10 status untouched", v, 32'h0000_0021);
  endtask

  task automatic t_reset_keep();
    logic [31:0] v;
    bus_wr(8'h00, 32'h0000_00F0);
    evt(8'h30);
    chk("R11 irq before reset", {31'd0, irq}, 32'd1);
    do_reset();
    chk("R11 irq cleared", {31'd0, irq}, 32'd0);
    bus_rd(8'h00, v);
    chk("R11 mask kept", v, 32'h0000_00F0);
    bus_rd(8'h04, v);
    chk("R11 status cleared", v, 32'h0);
  endtask

  initial begin
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    evt_valid = 0; evt_data = '0;
    cfg_max_peer = 16'd2;
    cfg_peer_vecs = {9'd5, 9'd0, 9'd1, 9'd3};
    cfg_own_id = 16'd7;
    cfg_mapped = 1'b1;
    do_reset();
    t_reset();
    t_mask_irq();
    t_status();
    t_race();
    t_bell();
    t_posn_undef();
    t_reset_keep();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule